// File: doc/BRIEF.md
# Reprogrammable Sum-of-Products Logic Plane

This block evaluates eight sum-of-products functions over sixteen input signals. Eight dedicated inputs and eight feedback inputs each produce a true line and a complement line, which gives 32 array lines. Sixty-four AND terms sample those lines through a connection matrix that stores one bit per line/term crossing. Each output owns eight terms. Seven of them are ORed into the output's sum. The eighth is brought out on its own, so that the downstream output cell can use it either as a further sum input or as an enable.

The matrix is configured through a small write port. Each write carries a term index and a 32-bit connection word, and the word is merged into that term's row. A write can only connect crossings; it never opens one. To start a new pattern, an erase strobe opens every crossing.

A two-state sequencer controls configuration. Its states are `CFG_IDLE` and `CFG_ERASE`. In `CFG_IDLE`, writes are applied. An erase strobe seen in `CFG_IDLE` takes the transition *erase-request* to `CFG_ERASE`. On the next edge the sequencer clears the whole matrix and takes the transition *erase-done* back to `CFG_IDLE`. Any write offered while the sequencer is in `CFG_ERASE`, or in the same cycle as the erase strobe, is dropped. Evaluation is purely combinational from the inputs and the stored matrix.

Top module: `sop_array`

## Requirements
- R1: Array line 2k carries signal k and line 2k+1 carries its complement. Signals 0 to 7 are `ded_in[7:0]` and signals 8 to 15 are `fb_in[7:0]`. Bit n of a connection word controls line n.
- R2: Output o uses terms 8o to 8o+7. `sum_out[o]` is the OR of terms 8o to 8o+6. `aux_term[o]` is term 8o+7 alone, and that term never enters the sum.
- R3: A term is the AND of every line whose crossing bit is connected.
- R4: A term with no connected crossing evaluates to 1.
- R5: A term connected to both the true line and the complement line of one signal evaluates to 0 for every input value.
- R6: A write in `CFG_IDLE` with `cfg_erase` low ORs `cfg_wdata` into row `cfg_term`. It never clears a bit, and all other rows are left unchanged.
- R7: `cfg_erase` high in `CFG_IDLE` moves the sequencer to `CFG_ERASE` at the next edge. The edge after that opens every crossing and returns the sequencer to `CFG_IDLE`. The outputs keep the old pattern until that second edge.
- R8: A write offered in `CFG_ERASE`, or in the same cycle as an accepted erase strobe, leaves the matrix unchanged.
- R9: Reset opens every crossing and puts the sequencer in `CFG_IDLE`, so both output buses read all ones.
- R10: Outputs follow input changes within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback input signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_term | input | 6 | Term index for the write |
| cfg_wdata | input | 32 | Connection word (1 = connect) |
| cfg_erase | input | 1 | Bulk erase request |
| sum_out | output | 8 | Sum per output |
| aux_term | output | 8 | Spare term per output |

## Verification
The bench builds the block with its default parameters: 8 dedicated inputs, 8 feedback inputs, 8 outputs and 7 summed terms per output. This gives the full 32-line by 64-term matrix, so every term index and every line position can be written. Directed patterns pin down the line mapping, the spare-term routing, the all-open and complementary-pair corner cases, accumulation of writes, and the timing of erase against colliding writes. Randomly programmed sparse matrices are then driven with random inputs and compared every cycle against a behavioural model.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic {
        CFG_IDLE  = 1'b0,
        CFG_ERASE = 1'b1
    } cfg_state_e;

    function automatic int line_count(input int n_ded, input int n_fb);
        return 2 * (n_ded + n_fb);
    endfunction

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
    import sop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_erase,
    output cfg_state_e state,
    output logic       do_write,
    output logic       do_clear
);

    cfg_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CFG_IDLE:  if (cfg_erase) state_nx = CFG_ERASE; // erase-request
            CFG_ERASE: state_nx = CFG_IDLE;                 // erase-done
            default:   state_nx = CFG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        do_write = 1'b0;
        do_clear = 1'b0;
        unique case (state)
            CFG_IDLE:  do_write = cfg_we && !cfg_erase;
            CFG_ERASE: do_clear = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int TERMS  = 64,
    parameter int LINES  = 32,
    parameter int TERM_W = $clog2(TERMS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         do_write,
    input  logic                         do_clear,
    input  logic [TERM_W-1:0]            wr_term,
    input  logic [LINES-1:0]             wr_data,
    output logic [TERMS-1:0][LINES-1:0]  rows
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows <= '0;
        end else if (do_clear) begin
            rows <= '0;
        end else if (do_write) begin
            rows[wr_term] <= rows[wr_term] | wr_data;
        end
    end

endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
    parameter int SIGS  = 16,
    parameter int TERMS = 64,
    parameter int LINES = 2 * SIGS
) (
    input  logic [SIGS-1:0]              sigs,
    input  logic [TERMS-1:0][LINES-1:0]  rows,
    output logic [TERMS-1:0]             terms
);

    logic [LINES-1:0] lines;

    for (genvar k = 0; k < SIGS; k++) begin : g_line
        assign lines[2*k]   = sigs[k];
        assign lines[2*k+1] = ~sigs[k];
    end

    // an open crossing contributes 1; a connected one passes its line
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign terms[t] = &(~rows[t] | lines);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT      = 8,
    parameter int PT_PER_OUT = 7,
    parameter int GRP        = PT_PER_OUT + 1,
    parameter int TERMS      = N_OUT * GRP
) (
    input  logic [TERMS-1:0] terms,
    output logic [N_OUT-1:0] sums,
    output logic [N_OUT-1:0] spares
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sums[o]   = |terms[o*GRP +: PT_PER_OUT];
        assign spares[o] = terms[o*GRP + PT_PER_OUT];
    end

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_DED      = 8,
    parameter int N_FB       = 8,
    parameter int N_OUT      = 8,
    parameter int PT_PER_OUT = 7,
    localparam int SIGS      = N_DED + N_FB,
    localparam int LINES     = line_count(N_DED, N_FB),
    localparam int GRP       = PT_PER_OUT + 1,
    localparam int TERMS     = N_OUT * GRP,
    localparam int TERM_W    = $clog2(TERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    input  logic              cfg_we,
    input  logic [TERM_W-1:0] cfg_term,
    input  logic [LINES-1:0]  cfg_wdata,
    input  logic              cfg_erase,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  aux_term
);

    cfg_state_e                 cfg_state;
    logic                       do_write;
    logic                       do_clear;
    logic [TERMS-1:0][LINES-1:0] cfg_rows;
    logic [TERMS-1:0]           terms;
    logic [SIGS-1:0]            sigs;

    assign sigs = {fb_in, ded_in};

    sop_cfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_erase(cfg_erase),
        .state    (cfg_state),
        .do_write (do_write),
        .do_clear (do_clear)
    );

    sop_cfg_store #(.TERMS(TERMS), .LINES(LINES), .TERM_W(TERM_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_write(do_write),
        .do_clear(do_clear),
        .wr_term (cfg_term),
        .wr_data (cfg_wdata),
        .rows    (cfg_rows)
    );

    sop_term_plane #(.SIGS(SIGS), .TERMS(TERMS), .LINES(LINES)) u_terms (
        .sigs (sigs),
        .rows (cfg_rows),
        .terms(terms)
    );

    sop_or_plane #(.N_OUT(N_OUT), .PT_PER_OUT(PT_PER_OUT), .GRP(GRP), .TERMS(TERMS)) u_or (
        .terms (terms),
        .sums  (sum_out),
        .spares(aux_term)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
    import sop_pkg::*;
#(
    parameter int TERMS  = 64,
    parameter int LINES  = 32,
    parameter int N_OUT  = 8,
    parameter int TERM_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_erase,
    input  logic [TERM_W-1:0]           cfg_term,
    input  logic [LINES-1:0]            cfg_wdata,
    input  cfg_state_e                  state,
    input  logic [TERMS-1:0][LINES-1:0] rows,
    input  logic [N_OUT-1:0]            sum_out,
    input  logic [N_OUT-1:0]            aux_term
);

    p_write_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_IDLE && cfg_we && !cfg_erase) |=>
        ((rows[$past(cfg_term)] & $past(cfg_wdata)) == $past(cfg_wdata)));

    p_never_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_IDLE) |=> ((rows & $past(rows)) == $past(rows)));

    p_erase_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_IDLE && cfg_erase) |=> (state == CFG_ERASE));

    p_erase_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_ERASE) |=> (state == CFG_IDLE && rows == '0));

    p_erase_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_ERASE) |=> (&sum_out && &aux_term));

    p_collide_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_IDLE && cfg_erase) |=> (rows == $past(rows)));

endmodule

bind sop_array sop_array_chk #(
    .TERMS(TERMS), .LINES(LINES), .N_OUT(N_OUT), .TERM_W(TERM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_erase(cfg_erase),
    .cfg_term (cfg_term),
    .cfg_wdata(cfg_wdata),
    .state    (cfg_state),
    .rows     (cfg_rows),
    .sum_out  (sum_out),
    .aux_term (aux_term)
);

// File: tb/sop_array_test.sv
`timescale 1ns/1ps
module sop_array_test;

    localparam int NT = 64;
    localparam int NO = 8;
    localparam int G  = 8;
    localparam int P  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_term = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_erase = 1'b0;
    logic [7:0]  sum_out;
    logic [7:0]  aux_term;

    always #5 clk = ~clk;

    sop_array uut (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_we(cfg_we), .cfg_term(cfg_term), .cfg_wdata(cfg_wdata),
        .cfg_erase(cfg_erase), .sum_out(sum_out), .aux_term(aux_term)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R9";

    logic [31:0] ref_rows [NT];
    bit          ref_erasing = 0;

    // behavioural model of the configuration side
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_rows[i]) ref_rows[i] = '0;
            ref_erasing = 0;
        end else if (ref_erasing) begin
            foreach (ref_rows[i]) ref_rows[i] = '0;
            ref_erasing = 0;
        end else if (cfg_erase) begin
            ref_erasing = 1;
        end else if (cfg_we) begin
            ref_rows[cfg_term] = ref_rows[cfg_term] | cfg_wdata;
        end
    end

    function automatic bit ref_term(int t);
        bit r = 1;
        for (int l = 0; l < 32; l++) begin
            if (ref_rows[t][l]) begin
                int  s = l / 2;
                bit  v = (s < 8) ? ded_in[s] : fb_in[s-8];
                if (l % 2 == 1) v = !v;
                r = r & v;
            end
        end
        return r;
    endfunction

    task automatic compare_model();
        logic [7:0] es, ea;
        for (int o = 0; o < NO; o++) begin
            es[o] = 0;
            for (int k = 0; k < P; k++) es[o] = es[o] | ref_term(o*G + k);
            ea[o] = ref_term(o*G + P);
        end
        vectors++;
        if (sum_out !== es) begin
            miscompares++;
            $display("FAIL %s model sum_out actual=%h expected=%h", cur_req, sum_out, es);
        end
        if (aux_term !== ea) begin
            miscompares++;
            $display("FAIL %s model aux_term actual=%h expected=%h", cur_req, aux_term, ea);
        end
    endtask

    task automatic expect_out(string req, logic [7:0] es, logic [7:0] ea);
        vectors++;
        if (sum_out !== es || aux_term !== ea) begin
            miscompares++;
            $display("FAIL %s sum/aux actual=%h/%h expected=%h/%h", req, sum_out, aux_term, es, ea);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        compare_model();
    endtask

    task automatic write_term(int t, logic [31:0] w);
        cfg_we = 1; cfg_term = 6'(t); cfg_wdata = w;
        step();
        cfg_we = 0;
    endtask

    task automatic erase();
        cfg_erase = 1;
        step();
        cfg_erase = 0;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R9: reset leaves every crossing open
        expect_out("R9", 8'hFF, 8'hFF);
        step();

        // R5: summed terms 1..6 of each output get a ded0 pair; R1: term 0 takes ded[o]
        cur_req = "R5";
        for (int o = 0; o < NO; o++)
            for (int k = 1; k < P; k++) write_term(o*G + k, 32'h3);
        cur_req = "R3";
        for (int o = 0; o < NO; o++) write_term(o*G, 32'h1 << (2*o));
        ded_in = 8'hA5; fb_in = 8'h00;
        #1 expect_out("R1", 8'hA5, 8'hFF);
        // R10: combinational response without a clock edge
        ded_in = 8'h5A;
        #2 expect_out("R10", 8'h5A, 8'hFF);
        compare_model();

        // R2: spare term takes complement of fb[o], does not reach the sums
        cur_req = "R2";
        for (int o = 0; o < NO; o++) write_term(o*G + P, 32'h1 << (2*(8+o)+1));
        ded_in = 8'hA5; fb_in = 8'h3C;
        #1 expect_out("R2", 8'hA5, 8'hC3);

        // R6: second write merges fb0 true into term 0
        cur_req = "R6";
        write_term(0, 32'h1 << 16);
        ded_in = 8'hFF; fb_in = 8'hFE;
        #1 expect_out("R6", 8'hFE, 8'h01);
        fb_in = 8'hFF;
        #1 expect_out("R6", 8'hFF, 8'h00);
        fb_in = 8'hFE;

        // R5: term 8 given ded1 complement beside ded1 true
        cur_req = "R5";
        write_term(8, 32'h1 << 3);
        #1 expect_out("R5", 8'hFC, 8'h01);
        ded_in = 8'h02;
        #1 expect_out("R5", 8'h00, 8'h01);
        ded_in = 8'hFF;

        // R7/R8: erase with a colliding write, then a write during the erase state
        cur_req = "R7";
        cfg_erase = 1; cfg_we = 1; cfg_term = 6'd23; cfg_wdata = 32'h3;
        step();
        expect_out("R7", 8'hFC, 8'h01);
        cfg_erase = 0;
        step();
        expect_out("R7", 8'hFF, 8'hFF);
        cfg_we = 0;
        step();
        expect_out("R8", 8'hFF, 8'hFF);
        ded_in = 8'h00; fb_in = 8'h00;
        #1 expect_out("R8", 8'hFF, 8'hFF);

        // R3/R4: random sparse matrices under random inputs
        cur_req = "R3";
        for (int round = 0; round < 4; round++) begin
            erase();
            for (int t = 0; t < NT; t++) begin
                logic [31:0] w = $urandom & $urandom & $urandom;
                if (t % 11 == round) w = '0;
                write_term(t, w);
            end
            for (int c = 0; c < 300; c++) begin
                ded_in = 8'($urandom);
                fb_in  = 8'($urandom);
                step();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule